// File: doc/BRIEF.md
# Dual-Lane Feistel Block Cipher Engine

This block encrypts or decrypts one 128-bit block at a time using two 64-bit Feistel lanes that work on the two halves of the block at the same time. Each lane runs 16 rounds of a four-table substitution round function over a pair of 32-bit halves, with an 18-word subkey array mixed in at each round and at the end. Encryption walks the subkey array forward and decryption walks it backward, so the same hardware serves both directions.

The four 256-entry, 32-bit substitution tables are kept in one shared memory of 1024 words with a registered read port. The eight lookups a round needs (four per lane) are issued one per cycle, so every round takes a fixed nine cycles and a whole block a fixed 144 cycles. Subkeys and table contents are loaded through simple write ports before use; deriving them from a user key is left to surrounding logic.

A caller presents the block and the direction, pulses `start`, and waits for the one-cycle `done` pulse, after which `dout` holds the result until the next accepted start.

Top module: `dual_feistel_engine`

## Requirements
- R1: Bits [127:64] of `din` are processed by the upper lane and bits [63:0] by the lower lane; `dout` is {upper lane result, lower lane result}, and the two lanes never mix data.
- R2: In encrypt mode (`decrypt`=0) each lane splits its 64 bits into L (upper 32) and R (lower 32); for round i = 0..15 it sets L ^= P[i], R ^= F(L), then swaps L and R; after round 15 the swap is undone, R ^= P[16] and L ^= P[17]; the result is {L, R}.
- R3: In decrypt mode the same flow uses P[17-i] in round i and finishes with R ^= P[1], L ^= P[0], so decrypting a ciphertext returns the plaintext; the direction is captured when a start is accepted and later changes of `decrypt` have no effect on that block.
- R4: F(x) = ((T0[a] + T1[b]) XOR T2[c]) + T3[d] modulo 2^32, where a..d are the bytes of x from most to least significant, and table t entry e sits at memory word address {t[1:0], e[7:0]} written through `tbl_we`/`tbl_addr`/`tbl_wdata`.
- R5: A write with `key_we` high stores `key_wdata` into subkey P[`key_sel`] for `key_sel` 0 to 17; writes with `key_sel` 18 to 31 change no subkey.
- R6: `done` rises exactly 144 clock edges after the edge that accepts `start` (nine cycles per round).
- R7: `busy` is high from the edge after an accepted start until the result is ready; `done` is a single-cycle pulse, asserted while `busy` is low.
- R8: A `start` pulse while `busy` is high is ignored: the running block completes with its own data and timing.
- R9: After reset `dout` is zero and `busy`, `done` are low; `dout` holds its value from `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin processing `din` (accepted only when idle) |
| decrypt | input | 1 | Direction: 0 encrypt, 1 decrypt, sampled with start |
| din | input | 128 | Input block |
| dout | output | 128 | Result block, valid from `done` |
| busy | output | 1 | Engine is running a block |
| done | output | 1 | One-cycle completion pulse |
| key_we | input | 1 | Subkey write enable |
| key_sel | input | 5 | Subkey index 0..17 |
| key_wdata | input | 32 | Subkey write data |
| tbl_we | input | 1 | Substitution memory write enable |
| tbl_addr | input | 10 | Substitution memory word address {table, entry} |
| tbl_wdata | input | 32 | Substitution memory write data |

## Verification
The engine is driven with all-zero and all-one blocks, blocks whose two lanes carry identical data, blocks whose lanes carry different and mirrored data, and spread bit patterns, each encrypted and then decrypted against a bench model of the round flow; identical lanes expose crosstalk or a swapped output order, while mirrored and spread patterns expose wrong byte-to-table mapping and wrong subkey order. Two different table and subkey fillings are used so a fixed-content or mis-addressed memory cannot pass. Separate runs toggle `decrypt` mid-block, pulse `start` mid-block with other data, write out-of-range subkey indices, and hold the engine idle with changing inputs, each observed only through `dout`, `busy` and `done`.

// File: rtl/dfe_pkg.sv
package dfe_pkg;

  typedef logic [31:0] word_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // Fold one table read into the round-function accumulator.
  // Table 0 seeds, 1 adds, 2 xors, 3 adds.
  function automatic word_t mix_step(input logic [1:0] tbl,
                                     input word_t acc,
                                     input word_t rd);
    word_t res;
    unique case (tbl)
      2'd0:    res = rd;
      2'd1:    res = acc + rd;
      2'd2:    res = acc ^ rd;
      default: res = acc + rd;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/dfe_sbox_ram.sv
module dfe_sbox_ram
  import dfe_pkg::*;
#(
  parameter int AW = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);

  word_t mem [DEPTH];
  word_t rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/dfe_subkeys.sv
module dfe_subkeys
  import dfe_pkg::*;
#(
  parameter int ROUNDS = 16,
  localparam int NKEYS = ROUNDS + 2,
  localparam int KW    = $clog2(NKEYS),
  localparam int RW    = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [KW-1:0] sel,
  input  word_t         wdata,
  input  logic          reverse,
  input  logic [RW-1:0] round_idx,
  output word_t         round_key,
  output word_t         final_l,
  output word_t         final_r
);

  word_t keys_q [NKEYS];
  logic [KW-1:0] rk_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NKEYS; k++) keys_q[k] <= '0;
    end else if (we && (int'(sel) < NKEYS)) begin
      keys_q[sel] <= wdata;
    end
  end

  always_comb begin
    if (reverse) begin
      rk_idx  = KW'(NKEYS - 1) - KW'(round_idx);
      final_r = keys_q[1];
      final_l = keys_q[0];
    end else begin
      rk_idx  = KW'(round_idx);
      final_r = keys_q[NKEYS-2];
      final_l = keys_q[NKEYS-1];
    end
    round_key = keys_q[rk_idx];
  end

endmodule

// File: rtl/dfe_seq.sv
module dfe_seq
  import dfe_pkg::*;
#(
  parameter int ROUNDS = 16,
  parameter int LANES  = 2,
  localparam int LOOKUPS = LANES * 4,
  localparam int PH_W    = $clog2(LOOKUPS + 1),
  localparam int RW      = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int LSEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              load,
  output logic              issue_valid,
  output logic [LSEL_W-1:0] issue_lane,
  output logic [1:0]        issue_tbl,
  output logic              rd_valid,
  output logic [LSEL_W-1:0] rd_lane,
  output logic [1:0]        rd_tbl,
  output logic              step,
  output logic              last,
  output logic [RW-1:0]     round_idx
);

  run_state_e        state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [RW-1:0]     round_q, round_d;
  logic              done_q, done_d;
  logic              rdv_q;
  logic [LSEL_W-1:0] rdl_q;
  logic [1:0]        rdt_q;

  assign busy        = (state_q == ST_RUN);
  assign load        = (state_q == ST_IDLE) && start;
  assign issue_valid = busy && (phase_q < PH_W'(LOOKUPS));
  assign issue_lane  = LSEL_W'(phase_q >> 2);
  assign issue_tbl   = phase_q[1:0];
  assign step        = busy && (phase_q == PH_W'(LOOKUPS));
  assign last        = (round_q == RW'(ROUNDS - 1));
  assign round_idx   = round_q;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    round_d = round_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          phase_d = '0;
          round_d = '0;
        end
      end
      ST_RUN: begin
        if (phase_q == PH_W'(LOOKUPS)) begin
          phase_d = '0;
          if (last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            round_d = round_q + 1'b1;
          end
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      round_q <= '0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      rdl_q   <= '0;
      rdt_q   <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      round_q <= round_d;
      done_q  <= done_d;
      rdv_q   <= issue_valid;
      if (issue_valid) begin
        rdl_q <= issue_lane;
        rdt_q <= issue_tbl;
      end
    end
  end

  assign done     = done_q;
  assign rd_valid = rdv_q;
  assign rd_lane  = rdl_q;
  assign rd_tbl   = rdt_q;

endmodule

// File: rtl/dfe_lane.sv
module dfe_lane
  import dfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [63:0] blk_in,
  input  word_t       pk,
  input  word_t       pfl,
  input  word_t       pfr,
  input  logic [1:0]  issue_tbl,
  output logic [7:0]  addr_byte,
  input  logic        rd_en,
  input  logic [1:0]  rd_tbl,
  input  word_t       rdata,
  input  logic        step,
  input  logic        last,
  output logic [63:0] blk_out
);

  word_t l_q, r_q, acc_q;
  word_t l_d, r_d, acc_d;
  word_t xl;

  assign xl = l_q ^ pk;

  always_comb begin
    unique case (issue_tbl)
      2'd0:    addr_byte = xl[31:24];
      2'd1:    addr_byte = xl[23:16];
      2'd2:    addr_byte = xl[15:8];
      default: addr_byte = xl[7:0];
    endcase
  end

  always_comb begin
    acc_d = rd_en ? mix_step(rd_tbl, acc_q, rdata) : acc_q;
    l_d   = l_q;
    r_d   = r_q;
    if (load) begin
      l_d = blk_in[63:32];
      r_d = blk_in[31:0];
    end else if (step) begin
      if (last) begin
        l_d = xl ^ pfl;
        r_d = r_q ^ acc_d ^ pfr;
      end else begin
        l_d = r_q ^ acc_d;
        r_d = xl;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q   <= '0;
      r_q   <= '0;
      acc_q <= '0;
    end else begin
      if (rd_en) acc_q <= acc_d;
      if (load || step) begin
        l_q <= l_d;
        r_q <= r_d;
      end
    end
  end

  assign blk_out = {l_q, r_q};

endmodule

// File: rtl/dual_feistel_engine.sv
module dual_feistel_engine
  import dfe_pkg::*;
#(
  parameter int ROUNDS = 16,
  parameter int LANES  = 2,
  localparam int BW     = LANES * 64,
  localparam int NKEYS  = ROUNDS + 2,
  localparam int KW     = $clog2(NKEYS),
  localparam int RW     = (ROUNDS > 1) ? $clog2(ROUNDS) : 1,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TAW    = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           decrypt,
  input  logic [BW-1:0]  din,
  output logic [BW-1:0]  dout,
  output logic           busy,
  output logic           done,
  input  logic           key_we,
  input  logic [KW-1:0]  key_sel,
  input  logic [31:0]    key_wdata,
  input  logic           tbl_we,
  input  logic [TAW-1:0] tbl_addr,
  input  logic [31:0]    tbl_wdata
);

  logic              load, issue_valid, rd_valid, step, last;
  logic [LSEL_W-1:0] issue_lane, rd_lane;
  logic [1:0]        issue_tbl, rd_tbl;
  logic [RW-1:0]     round_idx;
  logic              dir_q;
  word_t             round_key, final_l, final_r, rdata;
  logic [TAW-1:0]    raddr;
  logic [7:0]        lane_byte [LANES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else if (load) begin
      dir_q <= decrypt;
    end
  end

  dfe_seq #(.ROUNDS(ROUNDS), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .load       (load),
    .issue_valid(issue_valid),
    .issue_lane (issue_lane),
    .issue_tbl  (issue_tbl),
    .rd_valid   (rd_valid),
    .rd_lane    (rd_lane),
    .rd_tbl     (rd_tbl),
    .step       (step),
    .last       (last),
    .round_idx  (round_idx)
  );

  dfe_subkeys #(.ROUNDS(ROUNDS)) u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (key_we),
    .sel      (key_sel),
    .wdata    (key_wdata),
    .reverse  (dir_q),
    .round_idx(round_idx),
    .round_key(round_key),
    .final_l  (final_l),
    .final_r  (final_r)
  );

  assign raddr = {issue_tbl, lane_byte[issue_lane]};

  dfe_sbox_ram #(.AW(TAW)) u_tables (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (tbl_we),
    .waddr(tbl_addr),
    .wdata(tbl_wdata),
    .re   (issue_valid),
    .raddr(raddr),
    .rdata(rdata)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_rd_en;
    assign lane_rd_en = rd_valid && (rd_lane == LSEL_W'(g));

    dfe_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .blk_in   (din[64*g +: 64]),
      .pk       (round_key),
      .pfl      (final_l),
      .pfr      (final_r),
      .issue_tbl(issue_tbl),
      .addr_byte(lane_byte[g]),
      .rd_en    (lane_rd_en),
      .rd_tbl   (rd_tbl),
      .rdata    (rdata),
      .step     (step),
      .last     (last),
      .blk_out  (dout[64*g +: 64])
    );
  end

endmodule

// File: rtl/dfe_chk.sv
module dfe_chk #(
  parameter int ROUNDS = 16,
  parameter int LANES  = 2,
  localparam int LAT = ROUNDS * (LANES * 4 + 1),
  localparam int BW  = LANES * 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [BW-1:0] dout
);

  logic [15:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!busy) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 16'd1;
    end
  end

  // R6
  latency_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 16'(LAT)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  run_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(dout));

endmodule

bind dual_feistel_engine dfe_chk #(.ROUNDS(ROUNDS), .LANES(LANES)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .start(start),
  .busy (busy),
  .done (done),
  .dout (dout)
);

// File: tb/tb_dual_feistel_engine.sv
module tb_dual_feistel_engine;

  localparam int CLK_PERIOD = 10;
  localparam int ROUNDS = 16;
  localparam int LANES  = 2;
  localparam int LAT    = ROUNDS * (LANES * 4 + 1);

  logic         clk, rst_n, start, decrypt;
  logic [127:0] din, dout;
  logic         busy, done;
  logic         key_we, tbl_we;
  logic [4:0]   key_sel;
  logic [31:0]  key_wdata, tbl_wdata;
  logic [9:0]   tbl_addr;

  dual_feistel_engine #(.ROUNDS(ROUNDS), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .din(din), .dout(dout), .busy(busy), .done(done),
    .key_we(key_we), .key_sel(key_sel), .key_wdata(key_wdata),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [31:0] sb [1024];
  logic [31:0] pk [18];
  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_mdl(input logic [31:0] x);
    return ((sb[{2'd0, x[31:24]}] + sb[{2'd1, x[23:16]}]) ^ sb[{2'd2, x[15:8]}])
           + sb[{2'd3, x[7:0]}];
  endfunction

  function automatic logic [63:0] lane_mdl(input logic [63:0] x, input bit dec);
    logic [31:0] l, r, t;
    l = x[63:32];
    r = x[31:0];
    for (int i = 0; i < 16; i++) begin
      l = l ^ (dec ? pk[17-i] : pk[i]);
      r = r ^ f_mdl(l);
      t = l; l = r; r = t;
    end
    t = l; l = r; r = t;
    r = r ^ (dec ? pk[1] : pk[16]);
    l = l ^ (dec ? pk[0] : pk[17]);
    return {l, r};
  endfunction

  function automatic logic [127:0] blk_mdl(input logic [127:0] x, input bit dec);
    return {lane_mdl(x[127:64], dec), lane_mdl(x[63:0], dec)};
  endfunction

  task automatic load_tables(input logic [31:0] seed);
    for (int i = 0; i < 1024; i++) begin
      sb[i] = (32'(i) * 32'h9E3779B1) ^ {seed[15:0], seed[31:16]} ^ (32'(i) << 21);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 10'(i); tbl_wdata = sb[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_keys(input logic [31:0] seed);
    for (int k = 0; k < 18; k++) begin
      pk[k] = seed * 32'h2545F491 + 32'(k) * 32'h6A09E667;
      @(negedge clk);
      key_we = 1'b1; key_sel = 5'(k); key_wdata = pk[k];
    end
    @(negedge clk);
    key_we = 1'b0;
  endtask

  logic [127:0] res;
  int lat;

  // Runs one block; poke_at>0 pulses start with other data mid-run (R8).
  task automatic run_block(input logic [127:0] x, input bit dec, input int poke_at);
    @(negedge clk);
    din = x; decrypt = dec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    decrypt = ~dec;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) chk(busy == 1'b1, "R7 busy after start", 128'(busy), 128'd1);
      if (lat == poke_at) begin
        start = 1'b1; din = ~x;
      end else begin
        start = 1'b0;
      end
    end while (!done && lat < 2000);
    start = 1'b0;
    if (lat >= 2000) chk(1'b0, "R6 run hung", 128'(lat), 128'(LAT));
    res = dout;
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", 128'(done), 128'd0);
  endtask

  function automatic logic [127:0] pattern(input int p);
    case (p)
      0: return '0;
      1: return '1;
      2: return {64'h0123456789ABCDEF, 64'h0123456789ABCDEF};
      3: return {64'hFEDCBA9876543210, 64'h0123456789ABCDEF};
      4: return {64'h8000000000000001, 64'h0000000100000000};
      default: return {32'hDEADBEEF, 32'h00FF00FF, 32'hA5A55A5A, 32'h13579BDF};
    endcase
  endfunction

  initial begin
    logic [127:0] x, ct, held, exp;
    rst_n = 1'b0; start = 1'b0; decrypt = 1'b0; din = '0;
    key_we = 1'b0; key_sel = '0; key_wdata = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == '0, "R9 reset dout", dout, '0);
    chk(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", {busy, done}, 128'd0);

    for (int cfg = 0; cfg < 2; cfg++) begin
      load_tables(32'h1234_0000 + 32'(cfg) * 32'h0F0F_5A5A);
      load_keys(32'h0000_0031 + 32'(cfg) * 32'h7777);
      for (int p = 0; p < 6; p++) begin
        x = pattern(p);
        run_block(x, 1'b0, 0);
        ct = res;
        exp = blk_mdl(x, 1'b0);
        chk(ct == exp, "R2 R4 R1 encrypt vs model", ct, exp);
        chk(lat == LAT, "R6 latency", 128'(lat), 128'(LAT));
        if (p == 2) chk(ct[127:64] == ct[63:0], "R1 equal lanes", ct[127:64], ct[63:0]);
        run_block(ct, 1'b1, 0);
        chk(res == x, "R3 decrypt restores", res, x);
      end
    end

    // R8: start during busy ignored
    x = pattern(5);
    run_block(x, 1'b0, 20);
    exp = blk_mdl(x, 1'b0);
    chk(res == exp, "R8 start ignored while busy", res, exp);
    chk(lat == LAT, "R8 latency kept", 128'(lat), 128'(LAT));

    // R9: output held while idle with changing inputs
    held = dout;
    for (int k = 0; k < 12; k++) begin
      din = {4{32'(k) * 32'h1111_1111}};
      decrypt = k[0];
      @(negedge clk);
      chk(dout == held, "R9 dout held idle", dout, held);
    end

    // R5: out-of-range subkey writes ignored
    for (int k = 18; k < 32; k++) begin
      @(negedge clk);
      key_we = 1'b1; key_sel = 5'(k); key_wdata = 32'hFFFF_0000 ^ 32'(k);
    end
    @(negedge clk);
    key_we = 1'b0;
    x = pattern(3);
    run_block(x, 1'b0, 0);
    exp = blk_mdl(x, 1'b0);
    chk(res == exp, "R5 high subkey index ignored", res, exp);

    // R5: in-range write of last subkey takes effect
    pk[17] = 32'hC0FFEE11;
    @(negedge clk);
    key_we = 1'b1; key_sel = 5'd17; key_wdata = pk[17];
    @(negedge clk);
    key_we = 1'b0;
    run_block(x, 1'b0, 0);
    exp = blk_mdl(x, 1'b0);
    chk(res == exp, "R5 subkey 17 update", res, exp);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule